// File: doc/BRIEF.md
# DMA Channel Event Trigger Logic

This block gathers transfer requests for a bank of DMA channels (32 by default) and hands them, one at a time, to a downstream event queue. A request can come from four places: a rising edge on a peripheral event line, a software write to an event-set register, a transfer-completion report whose code names the channel with chaining requested, or a write into parameter memory that hits the trigger word of a quick channel. All four sources merge into one latched pending-event register. Software drops pending requests through a write-one-to-clear register.

Each channel also has an enable bit. Software changes it only through a write-one-to-set register and a write-one-to-clear register. A pending event is forwarded only while its channel is enabled. The block always presents the lowest-numbered channel that is both pending and enabled, together with that channel's programmed queue number. An acknowledge from the queue retires the presented event. The highest channels double as quick channels. A quick channel latches a request only when a parameter write lands on the set and word named in its mapping register and its enable bit is already set.

Top module: `dma_evt_trigger`

## Requirements
- R1: After reset the pending-event, enable and missed-event registers, the queue-number map and the quick mapping registers all read zero, and `q_valid` is low.
- R2: A write to address 4 sets every enable bit whose data bit is 1, and a write to address 5 clears every enable bit whose data bit is 1. Data bits of 0 change nothing. Address 3 reads the enable register.
- R3: A 0-to-1 change of `ext_evt[i]` between two clock edges latches pending bit i. A line that stays high latches no further request.
- R4: A write to address 1 latches pending bits where the data is 1. A write to address 2 drops them. When a clear and any request hit the same bit in one cycle, the bit ends up set. Address 0 reads the pending register.
- R5: `cmpl_valid` with `cmpl_chain` high latches the pending bit numbered `cmpl_code`. With `cmpl_chain` low the report has no effect.
- R6: Quick channel q is channel NCH-NQCH+q. Its mapping register is at address 16+q, with the parameter-set number in bits [6:0] and the trigger-word index in bits [18:16]. A `pw_valid` write with matching `pw_set` and `pw_word` latches that channel's pending bit only if its enable bit is already set. A write to another word of the same set does not latch it.
- R7: `q_valid` is high exactly when some channel is both pending and enabled, and `q_chan` is the lowest such channel. A pending but disabled channel is held and never presented.
- R8: The queue number of channel c is held at address 8+c/8, in bits [4*(c%8)+1 : 4*(c%8)]. The other bits read zero. `q_num` shows the field of the presented channel.
- R9: `q_ack` while `q_valid` is high clears the presented channel's pending bit at the next edge, unless a new request for that channel arrives in the same cycle, in which case the bit stays set. `q_ack` with `q_valid` low is ignored.
- R10: A request for a channel whose bit is already pending, and is not being dropped or acknowledged in that cycle, sets that channel's bit in the missed-event register at address 6. The bit stays set until a 1 is written to it at address 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset, released synchronously |
| wr_en | input | 1 | Register write strobe |
| addr | input | 6 | Register word address for reads and writes |
| wr_data | input | 32 | Register write data |
| rd_data | output | 32 | Read data for `addr`, combinational |
| ext_evt | input | 32 | Peripheral event lines, one per channel, synchronous |
| cmpl_valid | input | 1 | Transfer completion report valid |
| cmpl_chain | input | 1 | Completion report requests chaining |
| cmpl_code | input | 5 | Completion code, equal to the channel to chain to |
| pw_valid | input | 1 | A parameter-memory word is being written |
| pw_set | input | 7 | Parameter-set number of that write |
| pw_word | input | 3 | Word index within the set of that write |
| q_valid | output | 1 | A pending, enabled channel is presented |
| q_chan | output | 5 | Presented channel number |
| q_num | output | 2 | Event queue selected for the presented channel |
| q_ack | input | 1 | Queue accepts the presented channel |

## Verification
The hard cases are cycles where a retirement and a new request fall on the same pending bit: a queue acknowledge or a software clear together with a peripheral edge, a chained completion, or a software set for that channel. The bench provokes these on purpose, for example by raising the presented channel's event line in the same cycle as the acknowledge. It then checks both the surviving pending bit and the absence of a missed-event flag. A long random phase mixes every source, clears and acknowledges, so many more such collisions occur. The behavioural model decides each one by the set-wins rule.

// File: rtl/dma_trig_pkg.sv
`timescale 1ns/1ps
package dma_trig_pkg;
  // Register word addresses
  localparam int A_EVT  = 0;   // pending events, read
  localparam int A_EVS  = 1;   // pending set, write 1
  localparam int A_EVC  = 2;   // pending clear, write 1
  localparam int A_ENA  = 3;   // enables, read
  localparam int A_ENS  = 4;   // enable set, write 1
  localparam int A_ENC  = 5;   // enable clear, write 1
  localparam int A_MISS = 6;   // missed events, read / write 1 to clear
  localparam int A_MAP  = 8;   // queue-number map words
  localparam int A_QD   = 16;  // quick channel mapping words
  localparam int FLD_W  = 4;   // nibble per channel in map words
  localparam int QD_WORD_LSB = 16;
endpackage

// File: rtl/dma_trig_src.sv
`timescale 1ns/1ps
module dma_trig_src
  import dma_trig_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int CHW  = 5,
  parameter int NQCH = 4,
  parameter int PSW  = 7,
  parameter int WW   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NCH-1:0]             ext_evt,
  input  logic                       cmpl_valid,
  input  logic                       cmpl_chain,
  input  logic [CHW-1:0]             cmpl_code,
  input  logic                       pw_valid,
  input  logic [PSW-1:0]             pw_set,
  input  logic [WW-1:0]              pw_word,
  input  logic [NQCH-1:0][PSW-1:0]   qd_set,
  input  logic [NQCH-1:0][WW-1:0]    qd_word,
  input  logic [NQCH-1:0]            qd_ena,
  output logic [NCH-1:0]             req
);
  localparam int QBASE = NCH - NQCH;

  logic [NCH-1:0]  prev_q, prev_d;
  logic [NCH-1:0]  rise;
  logic [NCH-1:0]  chain_v;
  logic [NQCH-1:0] qhit;

  // edge detector state
  always_comb prev_d = ext_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  always_comb rise = ext_evt & ~prev_q;

  // chained completion decode
  always_comb begin
    chain_v = '0;
    for (int i = 0; i < NCH; i++) begin
      if (cmpl_valid && cmpl_chain && (cmpl_code == CHW'(i))) chain_v[i] = 1'b1;
    end
  end

  // quick channel trigger-word match, gated by the channel enable
  for (genvar q = 0; q < NQCH; q++) begin : g_qd
    assign qhit[q] = pw_valid && qd_ena[q] &&
                     (pw_set == qd_set[q]) && (pw_word == qd_word[q]);
  end

  always_comb req = rise | chain_v | (NCH'(qhit) << QBASE);
endmodule

// File: rtl/dma_trig_csr.sv
`timescale 1ns/1ps
module dma_trig_csr
  import dma_trig_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int DW   = 32,
  parameter int AW   = 6,
  parameter int QW   = 2,
  parameter int NQCH = 4,
  parameter int PSW  = 7,
  parameter int WW   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [AW-1:0]              addr,
  input  logic [DW-1:0]              wr_data,
  input  logic [NCH-1:0]             req,
  input  logic [NCH-1:0]             deq_mask,
  output logic [DW-1:0]              rd_data,
  output logic [NCH-1:0]             evt_q,
  output logic [NCH-1:0]             ena_q,
  output logic [NCH-1:0]             miss_q,
  output logic [NCH-1:0][QW-1:0]     qmap_q,
  output logic [NQCH-1:0][PSW-1:0]   qd_set_q,
  output logic [NQCH-1:0][WW-1:0]    qd_word_q
);
  localparam int FPW  = DW / FLD_W;   // channels per map word
  localparam int MAPW = NCH / FPW;    // map words

  logic [NCH-1:0] evs, evc, ens, enc, msc;
  logic [NCH-1:0] req_all, drop;
  logic [NCH-1:0] evt_d, ena_d, miss_d;
  logic           ena_ce;
  logic [NCH-1:0] map_we;
  logic [NCH-1:0][QW-1:0] map_d;
  logic [NQCH-1:0] qd_we;

  // write-one strobes
  always_comb begin
    evs = (wr_en && addr == AW'(A_EVS))  ? wr_data : '0;
    evc = (wr_en && addr == AW'(A_EVC))  ? wr_data : '0;
    ens = (wr_en && addr == AW'(A_ENS))  ? wr_data : '0;
    enc = (wr_en && addr == AW'(A_ENC))  ? wr_data : '0;
    msc = (wr_en && addr == AW'(A_MISS)) ? wr_data : '0;
  end

  // next state: set wins over clear and dequeue
  always_comb begin
    req_all = req | evs;
    drop    = evc | deq_mask;
    evt_d   = (evt_q & ~drop) | req_all;
    miss_d  = (miss_q & ~msc) | (req_all & evt_q & ~drop);
    ena_d   = (ena_q | ens) & ~enc;
    ena_ce  = |(ens | enc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= '0;
      miss_q <= '0;
    end else begin
      evt_q  <= evt_d;
      miss_q <= miss_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ena_q <= '0;
    else if (ena_ce) ena_q <= ena_d;
  end

  // per-channel queue-number fields
  for (genvar c = 0; c < NCH; c++) begin : g_map
    localparam int W = c / FPW;
    localparam int F = c % FPW;
    assign map_we[c] = wr_en && (addr == AW'(A_MAP + W));
    assign map_d[c]  = wr_data[F*FLD_W +: QW];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         qmap_q[c] <= '0;
      else if (map_we[c]) qmap_q[c] <= map_d[c];
    end
  end

  // quick channel mapping registers
  for (genvar q = 0; q < NQCH; q++) begin : g_qdreg
    assign qd_we[q] = wr_en && (addr == AW'(A_QD + q));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        qd_set_q[q]  <= '0;
        qd_word_q[q] <= '0;
      end else if (qd_we[q]) begin
        qd_set_q[q]  <= wr_data[PSW-1:0];
        qd_word_q[q] <= wr_data[QD_WORD_LSB +: WW];
      end
    end
  end

  // read mux
  always_comb begin
    rd_data = '0;
    if (addr == AW'(A_EVT))  rd_data = evt_q;
    if (addr == AW'(A_ENA))  rd_data = ena_q;
    if (addr == AW'(A_MISS)) rd_data = miss_q;
    for (int w = 0; w < MAPW; w++) begin
      if (addr == AW'(A_MAP + w)) begin
        for (int f = 0; f < FPW; f++) rd_data[f*FLD_W +: QW] = qmap_q[w*FPW + f];
      end
    end
    for (int q = 0; q < NQCH; q++) begin
      if (addr == AW'(A_QD + q)) begin
        rd_data[PSW-1:0]              = qd_set_q[q];
        rd_data[QD_WORD_LSB +: WW]    = qd_word_q[q];
      end
    end
  end
endmodule

// File: rtl/dma_trig_pick.sv
`timescale 1ns/1ps
module dma_trig_pick #(
  parameter int NCH = 32,
  parameter int CHW = 5,
  parameter int QW  = 2
) (
  input  logic [NCH-1:0]         evt,
  input  logic [NCH-1:0]         ena,
  input  logic [NCH-1:0][QW-1:0] qmap,
  input  logic                   ack,
  output logic                   valid,
  output logic [CHW-1:0]         chan,
  output logic [QW-1:0]          qnum,
  output logic [NCH-1:0]         deq_mask
);
  logic [NCH-1:0] pend;

  always_comb begin
    pend  = evt & ena;
    valid = |pend;
    chan  = '0;
    // scan downward so the lowest pending channel is the last assignment
    for (int i = NCH-1; i >= 0; i--) begin
      if (pend[i]) chan = CHW'(i);
    end
    qnum     = qmap[chan];
    deq_mask = (valid && ack) ? (NCH'(1) << chan) : '0;
  end
endmodule

// File: rtl/dma_evt_trigger.sv
`timescale 1ns/1ps
module dma_evt_trigger
  import dma_trig_pkg::*;
#(
  parameter int NCH  = 32,
  parameter int DW   = 32,
  parameter int AW   = 6,
  parameter int QW   = 2,
  parameter int NQCH = 4,
  parameter int PSW  = 7,
  parameter int WW   = 3,
  localparam int CHW = $clog2(NCH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [AW-1:0]   addr,
  input  logic [DW-1:0]   wr_data,
  output logic [DW-1:0]   rd_data,
  input  logic [NCH-1:0]  ext_evt,
  input  logic            cmpl_valid,
  input  logic            cmpl_chain,
  input  logic [CHW-1:0]  cmpl_code,
  input  logic            pw_valid,
  input  logic [PSW-1:0]  pw_set,
  input  logic [WW-1:0]   pw_word,
  output logic            q_valid,
  output logic [CHW-1:0]  q_chan,
  output logic [QW-1:0]   q_num,
  input  logic            q_ack
);
  localparam int QBASE = NCH - NQCH;

  logic [NCH-1:0]           req, deq_mask, evt_q, ena_q, miss_q;
  logic [NCH-1:0][QW-1:0]   qmap_q;
  logic [NQCH-1:0][PSW-1:0] qd_set_q;
  logic [NQCH-1:0][WW-1:0]  qd_word_q;

  dma_trig_src #(.NCH(NCH), .CHW(CHW), .NQCH(NQCH), .PSW(PSW), .WW(WW)) u_src (
    .clk(clk), .rst_n(rst_n), .ext_evt(ext_evt),
    .cmpl_valid(cmpl_valid), .cmpl_chain(cmpl_chain), .cmpl_code(cmpl_code),
    .pw_valid(pw_valid), .pw_set(pw_set), .pw_word(pw_word),
    .qd_set(qd_set_q), .qd_word(qd_word_q), .qd_ena(ena_q[QBASE +: NQCH]),
    .req(req)
  );

  dma_trig_csr #(.NCH(NCH), .DW(DW), .AW(AW), .QW(QW), .NQCH(NQCH), .PSW(PSW), .WW(WW)) u_csr (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
    .req(req), .deq_mask(deq_mask), .rd_data(rd_data),
    .evt_q(evt_q), .ena_q(ena_q), .miss_q(miss_q), .qmap_q(qmap_q),
    .qd_set_q(qd_set_q), .qd_word_q(qd_word_q)
  );

  dma_trig_pick #(.NCH(NCH), .CHW(CHW), .QW(QW)) u_pick (
    .evt(evt_q), .ena(ena_q), .qmap(qmap_q), .ack(q_ack),
    .valid(q_valid), .chan(q_chan), .qnum(q_num), .deq_mask(deq_mask)
  );
endmodule

// File: rtl/dma_trig_chk.sv
`timescale 1ns/1ps
module dma_trig_chk
  import dma_trig_pkg::*;
#(
  parameter int NCH = 32,
  parameter int DW  = 32,
  parameter int AW  = 6,
  parameter int CHW = 5
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wr_en,
  input logic [AW-1:0]   addr,
  input logic [DW-1:0]   wr_data,
  input logic            cmpl_valid,
  input logic            cmpl_chain,
  input logic [CHW-1:0]  cmpl_code,
  input logic            q_valid,
  input logic [CHW-1:0]  q_chan,
  input logic [NCH-1:0]  evt_q,
  input logic [NCH-1:0]  ena_q,
  input logic [NCH-1:0]  miss_q
);
  // R2
  ena_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(A_ENS)) |=> ((ena_q & $past(wr_data)) == $past(wr_data)));

  // R2
  ena_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(A_ENC)) |=> ((ena_q & $past(wr_data)) == '0));

  // R4
  evt_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == AW'(A_EVS)) |=> ((evt_q & $past(wr_data)) == $past(wr_data)));

  // R5
  chain_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_valid && cmpl_chain) |=> evt_q[$past(cmpl_code)]);

  // R7
  issue_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> (evt_q[q_chan] && ena_q[q_chan]));

  // R10
  miss_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && addr == AW'(A_MISS)) |=> ((miss_q & $past(miss_q)) == $past(miss_q)));
endmodule

bind dma_evt_trigger dma_trig_chk #(.NCH(NCH), .DW(DW), .AW(AW), .CHW(CHW)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
  .cmpl_valid(cmpl_valid), .cmpl_chain(cmpl_chain), .cmpl_code(cmpl_code),
  .q_valid(q_valid), .q_chan(q_chan),
  .evt_q(evt_q), .ena_q(ena_q), .miss_q(miss_q)
);

// File: tb/sim_dma_evt_trigger.sv
`timescale 1ns/1ps
module sim_dma_evt_trigger;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [5:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic [31:0] ext_evt = '0;
  logic        cmpl_valid = 1'b0, cmpl_chain = 1'b0;
  logic [4:0]  cmpl_code = '0;
  logic        pw_valid = 1'b0;
  logic [6:0]  pw_set = '0;
  logic [2:0]  pw_word = '0;
  logic        q_valid, q_ack = 1'b0;
  logic [4:0]  q_chan;
  logic [1:0]  q_num;

  int vectors = 0, fails = 0;
  bit done = 0, ack_mode = 0, active = 0;
  string cur = "R1";

  always #4 clk = ~clk;

  dma_evt_trigger u0 (.*);

  // ---------------- behavioural reference model ----------------
  bit [31:0] m_evt, m_ena, m_miss, m_prev;
  bit [31:0] m_map [4];
  bit [31:0] m_qd  [4];

  function automatic int m_low();
    for (int i = 0; i < 32; i++) if (m_evt[i] && m_ena[i]) return i;
    return -1;
  endfunction

  function automatic bit [1:0] m_qnum(int ch);
    return 2'((m_map[ch/8] >> (4*(ch%8))) & 3);
  endfunction

  function automatic bit [31:0] m_read(int a);
    if (a == 0) return m_evt;
    if (a == 3) return m_ena;
    if (a == 6) return m_miss;
    if (a >= 8 && a < 12) return m_map[a-8];
    if (a >= 16 && a < 20) return m_qd[a-16];
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_evt = 0; m_ena = 0; m_miss = 0; m_prev = 0;
      for (int k = 0; k < 4; k++) begin m_map[k] = 0; m_qd[k] = 0; end
    end else begin
      bit [31:0] rq, dr, nm;
      int lo;
      rq = 0; dr = 0;
      for (int i = 0; i < 32; i++) if (ext_evt[i] && !m_prev[i]) rq[i] = 1;
      if (cmpl_valid && cmpl_chain) rq[cmpl_code] = 1;
      for (int q = 0; q < 4; q++)
        if (pw_valid && m_ena[28+q] && pw_set == m_qd[q][6:0] && pw_word == m_qd[q][18:16])
          rq[28+q] = 1;
      if (wr_en && addr == 1) rq = rq | wr_data;
      if (wr_en && addr == 2) dr = wr_data;
      lo = m_low();
      if (q_ack && lo >= 0) dr[lo] = 1;
      nm = rq & m_evt & ~dr;
      if (wr_en && addr == 6) m_miss = m_miss & ~wr_data;
      m_miss = m_miss | nm;
      m_evt  = (m_evt & ~dr) | rq;
      if (wr_en && addr == 4) m_ena = m_ena | wr_data;
      if (wr_en && addr == 5) m_ena = m_ena & ~wr_data;
      if (wr_en && addr >= 8 && addr < 12) m_map[addr-8] = wr_data & 32'h3333_3333;
      if (wr_en && addr >= 16 && addr < 20) m_qd[addr-16] = wr_data & 32'h0007_007F;
      m_prev = ext_evt;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int lo;
    string rtag;
    lo = m_low();
    chk("R7", "q_valid", 32'(q_valid), 32'(lo >= 0));
    if (lo >= 0) begin
      chk("R7", "q_chan", 32'(q_chan), 32'(lo));
      chk("R8", "q_num", 32'(q_num), 32'(m_qnum(lo)));
    end
    rtag = cur;
    if (addr == 3) rtag = "R2";
    if (addr == 6) rtag = "R10";
    if (addr >= 8 && addr < 12) rtag = "R8";
    if (addr >= 16 && addr < 20) rtag = "R6";
    chk(rtag, $sformatf("rd_data@%0d", addr), rd_data, m_read(int'(addr)));
  endtask

  // one cycle: sample away from the edge, then drive defaults for next edge
  task automatic go();
    @(negedge clk);
    if (active) compare();
    wr_en = 0; cmpl_valid = 0; pw_valid = 0; q_ack = ack_mode;
  endtask

  task automatic wr(int a, logic [31:0] d);
    go(); wr_en = 1; addr = 6'(a); wr_data = d;
  endtask

  task automatic rd(int a);
    go(); addr = 6'(a);
  endtask

  initial begin
    #(8 * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1; active = 1;

    // R1: every readable register is zero after reset
    cur = "R1";
    for (int a = 0; a < 20; a++) rd(a);
    go(); chk("R1", "q_valid after reset", 32'(q_valid), 0);

    // R2: set/clear enables, zero data bits change nothing
    wr(4, 32'h0000_00F0); wr(4, 32'h0); wr(5, 32'h0000_0030); wr(5, 32'h0); rd(3); rd(3);

    // R4: software set/clear of pending bits on disabled channels
    cur = "R4";
    wr(1, 32'h0000_0300); rd(0); wr(2, 32'h0000_0100); rd(0);
    // clear and peripheral edge on channel 9 in one cycle: set wins
    wr(2, 32'h0000_0200); ext_evt[9] = 1; rd(0); rd(0); ext_evt[9] = 0;
    wr(2, 32'hFFFF_FFFF); rd(0);

    // R3: rising edge latches once, held level does not re-latch
    cur = "R3";
    ext_evt[20] = 1; rd(0); rd(0); rd(0); wr(2, 32'h0010_0000); rd(0); rd(0);
    ext_evt[20] = 0; rd(0); ext_evt[20] = 1; rd(0);
    ext_evt[20] = 0; rd(0); ext_evt[20] = 1; rd(6);   // second edge while pending
    cur = "R10"; rd(6); wr(6, 32'h0010_0000); rd(6); ext_evt[20] = 0;
    wr(2, 32'hFFFF_FFFF); rd(0);

    // R5: chained completion with and without chaining
    cur = "R5";
    go(); cmpl_valid = 1; cmpl_chain = 1; cmpl_code = 5'd13;
    go(); cmpl_valid = 1; cmpl_chain = 0; cmpl_code = 5'd14;
    rd(0); rd(0);
    wr(2, 32'hFFFF_FFFF);

    // R6: quick channel 0 = channel 28, set 3 word 2
    cur = "R6";
    wr(16, {13'd0, 3'd2, 9'd0, 7'd3}); rd(16);
    go(); pw_valid = 1; pw_set = 7'd3; pw_word = 3'd1;     // other word
    go(); pw_valid = 1; pw_set = 7'd3; pw_word = 3'd2;     // disabled
    rd(0);
    wr(4, 32'h1000_0000);
    go(); pw_valid = 1; pw_set = 7'd3; pw_word = 3'd1;
    rd(0);
    go(); pw_valid = 1; pw_set = 7'd3; pw_word = 3'd2;
    rd(0); wr(5, 32'h1000_0000); wr(2, 32'hFFFF_FFFF);

    // R7/R8: queue map and ordering with automatic acknowledge
    cur = "R7";
    wr(8,  32'h3210_0123); wr(9, 32'h1111_2222); wr(10, 32'hFFFF_FFFF); wr(11, 32'h0000_3333);
    rd(8); rd(9); rd(10); rd(11);
    wr(4, 32'hFFFF_FFFF);
    wr(1, 32'h8421_0A06); rd(0);
    ack_mode = 1;
    for (int k = 0; k < 10; k++) rd(0);
    ack_mode = 0; rd(0);

    // R9: ack plus same-cycle peripheral edge on the presented channel
    cur = "R9";
    wr(5, 32'hFFFF_FFFF); wr(4, 32'h0000_0004); wr(1, 32'h0000_0004); rd(0);
    go(); q_ack = 1; ext_evt[2] = 1; addr = 6'd0;
    rd(0); rd(6); ext_evt[2] = 0;
    go(); q_ack = 1; addr = 6'd0;      // plain ack retires channel 2
    rd(0); rd(6);
    wr(1, 32'h0000_0008); go(); q_ack = 1; rd(0);   // ack on disabled pending: ignored

    // random mix of every source
    cur = "R7";
    wr(2, 32'hFFFF_FFFF); wr(6, 32'hFFFF_FFFF);
    wr(17, {13'd0, 3'd1, 9'd0, 7'd2}); wr(18, {13'd0, 3'd3, 9'd0, 7'd1});
    for (int n = 0; n < 1500; n++) begin
      int r;
      go();
      r = int'($urandom % 16);
      q_ack = $urandom % 3 == 0;
      if ($urandom % 4 == 0) ext_evt[$urandom % 32] ^= 1'b1;
      if ($urandom % 5 == 0) begin
        cmpl_valid = 1; cmpl_chain = $urandom % 2 == 0; cmpl_code = 5'($urandom);
      end
      if ($urandom % 5 == 0) begin
        pw_valid = 1; pw_set = 7'($urandom % 4); pw_word = 3'($urandom % 4);
      end
      case (r)
        0: begin wr_en = 1; addr = 6'd1; wr_data = $urandom & $urandom; end
        1: begin wr_en = 1; addr = 6'd2; wr_data = $urandom & $urandom; end
        2: begin wr_en = 1; addr = 6'd4; wr_data = $urandom; end
        3: begin wr_en = 1; addr = 6'd5; wr_data = $urandom & $urandom; end
        4: begin wr_en = 1; addr = 6'd6; wr_data = $urandom; end
        5: begin wr_en = 1; addr = 6'(8 + $urandom % 4); wr_data = $urandom; end
        default: addr = 6'($urandom % 20);
      endcase
    end
    go();

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule